// File: doc/BRIEF.md
# Snoop Writeback Line Buffer

This block is a one-entry holding buffer inside a bus interface. When a snoop finds a modified cache line that has to leave the cache, the line (32 bytes by default) and its physical line address are captured here. The buffer then presents the line to the external bus as a write burst of four 64-bit beats. While the entry is occupied, further snoop writeback requests are back-pressured through `cap_ready`.

The buffer sits beside an independent replacement/invalidation writeback path. That path reaches the same bus through a small arbiter inside this block. When both sources ask for an idle bus in the same cycle, the snoop line wins. A burst that has had a beat accepted keeps the bus until its final beat, and neither source preempts the other. A replacement burst can therefore be in flight while a snoop line is being captured, and the two writebacks overlap.

The drain controller has three states:
- `DR_EMPTY`: no line held; `cap_ready` is high.
- `DR_PENDING`: a line is held but no beat has been accepted yet.
- `DR_BURST`: at least one beat has been accepted.

Its transitions are:
- EMPTY→PENDING on an accepted capture.
- PENDING→BURST on the first acknowledged beat that is not the last.
- PENDING→EMPTY or BURST→EMPTY on acknowledgement of the last beat.

The bus owner register has three values: `OWN_NONE`, `OWN_SNOOP` and `OWN_REPL`. It moves from NONE to a source when that source has a non-final beat acknowledged. It returns to NONE when a final beat is acknowledged.

Top module: `snpwb_buffer`

## Requirements
- R1: After reset `cap_ready` is 1 and `bus_req` is 0.
- R2: With `cap_ready` high, `cap_valid` high and `cap_cause` equal to 0 (internal snoop raised by an instruction-fetch miss) or 1 (external inquire hitting a modified line with invalidate asserted), the line is captured. From the next cycle `cap_ready` is 0 and `bus_req` is 1.
- R3: Cause 2 (external inquire hit without invalidate) and cause 3 (reserved) do not load the buffer: `cap_ready` stays 1 and no bus request appears.
- R4: While a line is held, `cap_ready` is 0 and any request is ignored. The held line is the one drained, unchanged.
- R5: The drain is four beats in ascending order. Beat k carries `cap_line[64k+63:64k]`, and `bus_last` is 1 only on beat 3. A beat advances only on a cycle with `bus_req` and `bus_ack` both high.
- R6: Beat k's address is the captured address with its low 5 bits cleared, plus 8k.
- R7: The cycle after the last beat is acknowledged, `cap_ready` is 1 and (with no replacement request) `bus_req` is 0.
- R8: When the owner is NONE and both sources request, the bus shows the snoop beat, and `repl_ack` stays 0 on an acknowledge.
- R9: Once a replacement beat other than its last is acknowledged, the replacement source keeps the bus until it signals `repl_last`. During that time `bus_ack` is routed to `repl_ack`, and a snoop capture is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Snoop writeback capture request |
| cap_cause | input | 2 | Snoop cause code (0, 1 load; 2, 3 do not) |
| cap_addr | input | 32 | Physical address of the line |
| cap_line | input | 256 | Line contents, byte 0 in the low bits |
| cap_ready | output | 1 | Buffer empty, capture possible |
| repl_req | input | 1 | Replacement path requests the bus |
| repl_addr | input | 32 | Replacement beat address |
| repl_wdata | input | 64 | Replacement beat data |
| repl_last | input | 1 | Replacement beat is its burst's last |
| repl_ack | output | 1 | Replacement beat accepted |
| bus_req | output | 1 | Beat valid on the bus |
| bus_addr | output | 32 | Beat address |
| bus_wdata | output | 64 | Beat data |
| bus_last | output | 1 | Final beat of the burst |
| bus_ack | input | 1 | Bus accepts the current beat |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 32-byte lines and 64-bit beats. With these values a full drain is four beats and an unaligned address exercises all five dropped offset bits. The bench sweeps all four cause codes against three acknowledge wait patterns (0 to 2 idle cycles per beat). On one of these patterns it holds a competing capture request throughout the drain. It then steps through the two arbitration orders: a simultaneous request from both sources, and a snoop capture that arrives during a locked replacement burst.

// File: rtl/snpwb_pkg.sv
package snpwb_pkg;

    typedef enum logic [1:0] {
        CAUSE_IFETCH_SNOOP = 2'd0,
        CAUSE_INQ_INVAL    = 2'd1,
        CAUSE_INQ_KEEP     = 2'd2,
        CAUSE_RSVD         = 2'd3
    } snp_cause_e;

    typedef enum logic [1:0] {
        DR_EMPTY   = 2'd0,
        DR_PENDING = 2'd1,
        DR_BURST   = 2'd2
    } drain_state_e;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_SNOOP = 2'd1,
        OWN_REPL  = 2'd2
    } bus_owner_e;

    function automatic logic cause_loads(input logic [1:0] cause);
        return (cause == CAUSE_IFETCH_SNOOP) || (cause == CAUSE_INQ_INVAL);
    endfunction

endpackage

// File: rtl/snpwb_line_store.sv
module snpwb_line_store #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 256,
    parameter int BEAT_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic [ADDR_W-1:0]             load_addr,
    input  logic [LINE_W-1:0]             load_line,
    input  logic [$clog2(LINE_W/BEAT_W)-1:0] beat_idx,
    output logic [ADDR_W-1:0]             beat_addr,
    output logic [BEAT_W-1:0]             beat_data
);
    localparam int BEATS  = LINE_W / BEAT_W;
    localparam int IDX_W  = $clog2(BEATS);
    localparam int BOFF_W = $clog2(BEAT_W / 8);
    localparam int OFF_W  = IDX_W + BOFF_W;

    logic [LINE_W-1:0]       line_q;
    logic [ADDR_W-OFF_W-1:0] base_q;
    logic [BEAT_W-1:0]       beat_slice [BEATS];
    logic                    unused_low_bits;

    assign unused_low_bits = ^load_addr[OFF_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            base_q <= '0;
        end else if (load_en) begin
            line_q <= load_line;
            base_q <= load_addr[ADDR_W-1:OFF_W];
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        assign beat_slice[g] = line_q[g*BEAT_W +: BEAT_W];
    end

    assign beat_data = beat_slice[beat_idx];
    assign beat_addr = {base_q, beat_idx, {BOFF_W{1'b0}}};

endmodule

// File: rtl/snpwb_drain_fsm.sv
module snpwb_drain_fsm
    import snpwb_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_fire,
    input  logic                     beat_ack,
    output logic                     ready,
    output logic                     req,
    output logic                     last,
    output logic [$clog2(BEATS)-1:0] beat_idx
);
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    drain_state_e     state_q, state_d;
    logic [IDX_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_EMPTY;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (beat_ack) begin
                beat_q <= (beat_q == LAST_IDX) ? '0 : beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_EMPTY:   if (cap_fire) state_d = DR_PENDING;
            DR_PENDING: if (beat_ack) state_d = (beat_q == LAST_IDX) ? DR_EMPTY : DR_BURST;
            DR_BURST:   if (beat_ack && beat_q == LAST_IDX) state_d = DR_EMPTY;
            default:    state_d = DR_EMPTY;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        req      = 1'b0;
        unique case (state_q)
            DR_EMPTY:   ready = 1'b1;
            DR_PENDING: req   = 1'b1;
            DR_BURST:   req   = 1'b1;
            default:    ready = 1'b0;
        endcase
        last     = (beat_q == LAST_IDX);
        beat_idx = beat_q;
    end

    AST_BEAT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && !last) |=> (beat_idx == IDX_W'($past(beat_idx) + 1'b1))); // R5
    AST_FREE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ack && last) |=> ready); // R7
    AST_STALL_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !(beat_ack && last)) |=> !ready); // R4

endmodule

// File: rtl/snpwb_bus_arb.sv
module snpwb_bus_arb
    import snpwb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_req,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [BEAT_W-1:0] snp_data,
    input  logic              snp_last,
    output logic              snp_ack,
    input  logic              repl_req,
    input  logic [ADDR_W-1:0] repl_addr,
    input  logic [BEAT_W-1:0] repl_wdata,
    input  logic              repl_last,
    output logic              repl_ack,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BEAT_W-1:0] bus_wdata,
    output logic              bus_last,
    input  logic              bus_ack
);
    bus_owner_e owner_q, owner_d;
    logic       grant_snp, grant_repl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    always_comb begin
        grant_snp  = 1'b0;
        grant_repl = 1'b0;
        unique case (owner_q)
            OWN_NONE: begin
                grant_snp  = snp_req;
                grant_repl = !snp_req && repl_req;
            end
            OWN_SNOOP: grant_snp  = 1'b1;
            OWN_REPL:  grant_repl = 1'b1;
            default:   grant_snp  = 1'b0;
        endcase

        bus_req   = (grant_snp && snp_req) || (grant_repl && repl_req);
        bus_addr  = grant_snp ? snp_addr : repl_addr;
        bus_wdata = grant_snp ? snp_data : repl_wdata;
        bus_last  = grant_snp ? snp_last : repl_last;
        snp_ack   = grant_snp && snp_req && bus_ack;
        repl_ack  = grant_repl && repl_req && bus_ack;

        owner_d = owner_q;
        if (bus_req && bus_ack) begin
            if (bus_last)       owner_d = OWN_NONE;
            else if (grant_snp) owner_d = OWN_SNOOP;
            else                owner_d = OWN_REPL;
        end
    end

    AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({snp_ack, repl_ack})); // R9
    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_NONE && snp_req && repl_req) |-> (bus_addr == snp_addr && !repl_ack)); // R8
    AST_HOLD_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (repl_ack && !repl_last) |=> !snp_ack); // R9

endmodule

// File: rtl/snpwb_buffer.sv
module snpwb_buffer
    import snpwb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_valid,
    input  logic [1:0]              cap_cause,
    input  logic [ADDR_W-1:0]       cap_addr,
    input  logic [LINE_BYTES*8-1:0] cap_line,
    output logic                    cap_ready,
    input  logic                    repl_req,
    input  logic [ADDR_W-1:0]       repl_addr,
    input  logic [BEAT_W-1:0]       repl_wdata,
    input  logic                    repl_last,
    output logic                    repl_ack,
    output logic                    bus_req,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [BEAT_W-1:0]       bus_wdata,
    output logic                    bus_last,
    input  logic                    bus_ack
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEATS  = LINE_W / BEAT_W;
    localparam int IDX_W  = $clog2(BEATS);
    localparam int OFF_W  = $clog2(LINE_BYTES);

    logic              cap_fire;
    logic              snp_req, snp_last, snp_ack;
    logic [IDX_W-1:0]  beat_idx;
    logic [ADDR_W-1:0] snp_addr;
    logic [BEAT_W-1:0] snp_data;

    assign cap_fire = cap_valid && cap_ready && cause_loads(cap_cause);

    snpwb_line_store #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .BEAT_W(BEAT_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (cap_fire),
        .load_addr (cap_addr),
        .load_line (cap_line),
        .beat_idx  (beat_idx),
        .beat_addr (snp_addr),
        .beat_data (snp_data)
    );

    snpwb_drain_fsm #(.BEATS(BEATS)) i_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fire (cap_fire),
        .beat_ack (snp_ack),
        .ready    (cap_ready),
        .req      (snp_req),
        .last     (snp_last),
        .beat_idx (beat_idx)
    );

    snpwb_bus_arb #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .snp_req    (snp_req),
        .snp_addr   (snp_addr),
        .snp_data   (snp_data),
        .snp_last   (snp_last),
        .snp_ack    (snp_ack),
        .repl_req   (repl_req),
        .repl_addr  (repl_addr),
        .repl_wdata (repl_wdata),
        .repl_last  (repl_last),
        .repl_ack   (repl_ack),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_last   (bus_last),
        .bus_ack    (bus_ack)
    );

    AST_CAPTURE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (!cap_ready && bus_req)); // R2
    AST_IGNORE_NONLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_ready && !cause_loads(cap_cause)) |=> cap_ready); // R3
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_ack && beat_idx == '0) |-> (bus_addr[OFF_W-1:0] == '0)); // R6

endmodule

// File: tb/test_snpwb_buffer.sv
module test_snpwb_buffer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_valid = 1'b0;
    logic [1:0]   cap_cause = 2'd0;
    logic [31:0]  cap_addr = '0;
    logic [255:0] cap_line = '0;
    logic         cap_ready;
    logic         repl_req = 1'b0;
    logic [31:0]  repl_addr = '0;
    logic [63:0]  repl_wdata = '0;
    logic         repl_last = 1'b0;
    logic         repl_ack;
    logic         bus_req;
    logic [31:0]  bus_addr;
    logic [63:0]  bus_wdata;
    logic         bus_last;
    logic         bus_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    snpwb_buffer i_snpwb_buffer (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_cause(cap_cause),
        .cap_addr(cap_addr), .cap_line(cap_line), .cap_ready(cap_ready),
        .repl_req(repl_req), .repl_addr(repl_addr), .repl_wdata(repl_wdata),
        .repl_last(repl_last), .repl_ack(repl_ack), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_last(bus_last),
        .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] line_of(input int c, input int p);
        logic [255:0] l;
        for (int k = 0; k < 4; k++)
            l[64*k +: 64] = {16'(c), 16'(p), 16'(k), 16'h5A3C ^ 16'(c * 7 + p)};
        return l;
    endfunction

    function automatic logic [31:0] addr_of(input int c, input int p);
        return 32'h4000_0000 + 32'(c) * 32'h1000 + 32'(p) * 32'h60 + 32'h17;
    endfunction

    // Entered just after a negedge with the snoop line pending on the bus.
    task automatic drain(input logic [31:0] addr, input logic [255:0] line,
                         input int waits, input bit stall, input int k0);
        logic [31:0] base;
        base = addr & ~32'h1F;
        for (int k = k0; k < 4; k++) begin
            if (stall && k < 3) begin
                cap_valid = 1'b1; cap_cause = 2'd0;
                cap_addr = ~addr; cap_line = ~line;
            end else begin
                cap_valid = 1'b0;
            end
            for (int w = 0; w < waits; w++) begin
                #1;
                chk(bus_req == 1'b1, "R5 request held", 64'(bus_req), 64'd1);
                chk(bus_addr == base + 32'(8 * k), "R5 no advance without ack", 64'(bus_addr), 64'(base + 32'(8 * k)));
                chk(cap_ready == 1'b0, "R4 stalled", 64'(cap_ready), 64'd0);
                @(negedge clk);
            end
            bus_ack = 1'b1;
            #1;
            chk(bus_addr == base + 32'(8 * k), "R6 beat address", 64'(bus_addr), 64'(base + 32'(8 * k)));
            chk(bus_wdata == line[64*k +: 64], "R5 beat data", bus_wdata, line[64*k +: 64]);
            chk(bus_last == (k == 3), "R5 last flag", 64'(bus_last), 64'(k == 3));
            chk(cap_ready == 1'b0, "R4 full", 64'(cap_ready), 64'd0);
            @(negedge clk);
            bus_ack = 1'b0;
        end
        #1;
        chk(cap_ready == 1'b1, "R7 freed", 64'(cap_ready), 64'd1);
        if (!repl_req) chk(bus_req == 1'b0, "R7 bus idle", 64'(bus_req), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(cap_ready == 1'b1, "R1 ready", 64'(cap_ready), 64'd1);
        chk(bus_req == 1'b0, "R1 bus_req", 64'(bus_req), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                cap_valid = 1'b1; cap_cause = 2'(c);
                cap_addr = addr_of(c, p); cap_line = line_of(c, p);
                #1;
                chk(cap_ready == 1'b1, "R2 ready before capture", 64'(cap_ready), 64'd1);
                @(negedge clk);
                cap_valid = 1'b0;
                #1;
                if (c < 2) begin
                    chk(cap_ready == 1'b0, "R2 captured", 64'(cap_ready), 64'd0);
                    chk(bus_req == 1'b1, "R2 bus request", 64'(bus_req), 64'd1);
                    drain(addr_of(c, p), line_of(c, p), p, p == 1, 0);
                end else begin
                    chk(cap_ready == 1'b1, "R3 not loaded", 64'(cap_ready), 64'd1);
                    chk(bus_req == 1'b0, "R3 no request", 64'(bus_req), 64'd0);
                end
            end
        end

        // R8: simultaneous request, snoop first
        @(negedge clk);
        repl_req = 1'b1; repl_addr = 32'h8000_0040; repl_wdata = 64'hDEAD_BEEF_0000_0001; repl_last = 1'b0;
        cap_valid = 1'b1; cap_cause = 2'd1; cap_addr = 32'h1234_5678; cap_line = line_of(9, 9);
        #1;
        chk(bus_addr == 32'h8000_0040, "R8 repl alone shown", 64'(bus_addr), 64'h8000_0040);
        @(negedge clk);
        cap_valid = 1'b0;
        bus_ack = 1'b1;
        #1;
        chk(bus_addr == 32'h1234_5660, "R8 snoop wins", 64'(bus_addr), 64'h1234_5660);
        chk(repl_ack == 1'b0, "R8 repl not acked", 64'(repl_ack), 64'd0);
        @(negedge clk);
        bus_ack = 1'b0;
        drain(32'h1234_5678, line_of(9, 9), 0, 1'b0, 1);
        chk(bus_addr == 32'h8000_0040, "R8 repl follows", 64'(bus_addr), 64'h8000_0040);

        // R9: locked replacement burst, snoop capture meanwhile
        bus_ack = 1'b1;
        #1;
        chk(repl_ack == 1'b1, "R9 repl ack routed", 64'(repl_ack), 64'd1);
        @(negedge clk);
        bus_ack = 1'b0; repl_addr = 32'h8000_0048;
        cap_valid = 1'b1; cap_cause = 2'd0; cap_addr = 32'h0000_ABCD; cap_line = line_of(5, 1);
        #1;
        chk(cap_ready == 1'b1, "R9 capture while repl busy", 64'(cap_ready), 64'd1);
        @(negedge clk);
        cap_valid = 1'b0;
        #1;
        chk(cap_ready == 1'b0, "R9 snoop held", 64'(cap_ready), 64'd0);
        chk(bus_addr == 32'h8000_0048, "R9 no preemption", 64'(bus_addr), 64'h8000_0048);
        bus_ack = 1'b1; repl_last = 1'b1;
        #1;
        chk(repl_ack == 1'b1, "R9 repl last ack", 64'(repl_ack), 64'd1);
        @(negedge clk);
        bus_ack = 1'b0; repl_req = 1'b0; repl_last = 1'b0;
        #1;
        chk(bus_addr == 32'h0000_ABC0, "R9 snoop after repl", 64'(bus_addr), 64'h0000_ABC0);
        drain(32'h0000_ABCD, line_of(5, 1), 1, 1'b0, 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule